// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Buffer

This block is a direct-mapped data cache. It sits between a processor load/store port and a memory that has separate line-read and word-write channels. A byte address splits into three fields. The lowest bits give the byte offset within a line; the word-select part of that offset picks a word of the line. The next bits pick one cache line, and the remaining high bits form the tag that is stored with that line. A load hits when the selected line is valid and its stored tag equals the address tag. A hit is answered one cycle after the request is accepted, with no memory traffic.

Stores are write-through and never allocate a line. Every store enters a four-entry store queue, which drains one word at a time to memory while the processor keeps issuing requests. A store that hits also updates the cached word in the same cycle. A store that misses leaves the cache untouched.

A load first searches the queue. If one or more queued stores target its word, the youngest one supplies the data and memory is not read. Otherwise a load miss fetches the whole line in one transfer. The fill request may overtake queued stores to other lines. It is held back while any queued store targets the same line, so the line that arrives already contains those stores.

Top module: `wt_dcache`

## Requirements
- R1: Addresses are word-aligned byte addresses (two low bits zero). Bits [3:2] select the word, bits [6:4] select one of 8 lines, and bits [11:7] form the tag. Two addresses with equal line bits and different tags evict each other.
- R2: A load whose line is valid with a matching tag returns the cached word with `cpu_resp_valid` one cycle after acceptance, and issues no memory read.
- R3: A load that misses both the cache and the store queue issues one line read at the line-aligned address. It returns the addressed word of the delivered line one cycle after `mem_rd_data_valid`.
- R4: Every accepted store is later written to memory at its own address with its data. A store that hits also updates the cached word, so a following load of that word returns the new value without a memory read.
- R5: A store miss allocates nothing: a later load of that address still issues a line read.
- R6: The store queue holds 4 entries. A store offered while the queue is full sees `cpu_req_ready` low until an entry drains.
- R7: A load that matches queued stores returns the data of the youngest matching store one cycle after acceptance, with no memory read, even when the cache misses.
- R8: A line read proceeds while queued stores target other lines only. While any queued store targets the missed line, `mem_rd_valid` stays low until those stores have drained.
- R9: Once raised, `mem_rd_valid` and `mem_wr_valid` stay high with stable address and data until the matching ready is seen.
- R10: After reset every line is invalid and the store queue is empty: no memory request is pending, and the first load misses.
- R11: Queued stores reach memory in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when high |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address, word-aligned |
| cpu_req_wdata | input | WORD_W | Store data |
| cpu_resp_valid | output | 1 | Load data valid (one cycle pulse) |
| cpu_resp_rdata | output | WORD_W | Load data |
| mem_rd_valid | output | 1 | Line read request |
| mem_rd_ready | input | 1 | Memory accepts the line read |
| mem_rd_addr | output | ADDR_W | Line-aligned read address |
| mem_rd_data_valid | input | 1 | Line data delivered (one cycle) |
| mem_rd_data | input | LINE_BYTES*8 | Whole line, word 0 in the low bits |
| mem_wr_valid | output | 1 | Word write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | ADDR_W | Word write address |
| mem_wr_data | output | WORD_W | Word write data |

## Verification
The hardest situation to reach is a load miss whose line is also the target of a store that is still queued: left alone, the queue drains within a cycle or two. The bench holds `mem_wr_ready` low so that stores pile up. It then issues a load to another word of the same line and watches `mem_rd_valid` stay low for several cycles before it releases the write channel. The same stall on the write side fills the queue to drive the full-queue stall and the youngest-match forwarding.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_DRAIN_WAIT,
      FS_REQ,
      FS_WAIT
   } fill_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
   parameter int LINES  = 8,
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 5,
   parameter int WORD_W = 32,
   parameter int WSEL_W = 2,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lk_idx,
   output logic              lk_valid,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [LINE_W-1:0] lk_line,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [WORD_W-1:0] wr_word
);

   logic [LINES-1:0]             vld_all;
   logic [LINES-1:0][TAG_W-1:0]  tag_all;
   logic [LINES-1:0][LINE_W-1:0] line_all;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      logic [LINE_W-1:0] d_q;
      logic              sel_fill;
      logic              sel_wr;

      assign sel_fill = fill_en && (fill_idx == IDX_W'(g));
      assign sel_wr   = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
         end else if (sel_fill) begin
            v_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_fill) begin
            t_q <= fill_tag;
            d_q <= fill_line;
         end else if (sel_wr) begin
            d_q[wr_wsel*WORD_W +: WORD_W] <= wr_word;
         end
      end

      assign vld_all[g]  = v_q;
      assign tag_all[g]  = t_q;
      assign line_all[g] = d_q;

      // R5: a line only becomes valid through a line fill, never through a store
      a_r5_alloc_only_on_fill : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(v_q) |-> $past(fill_en && (fill_idx == IDX_W'(g))));
   end

   assign lk_valid = vld_all[lk_idx];
   assign lk_tag   = tag_all[lk_idx];
   assign lk_line  = line_all[lk_idx];

endmodule

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int DEPTH  = 4,
   parameter int WA_W   = 10,
   parameter int WORD_W = 32,
   parameter int WSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WA_W-1:0]   push_waddr,
   input  logic [WORD_W-1:0] push_data,
   output logic              full,
   input  logic              pop,
   output logic              head_valid,
   output logic [WA_W-1:0]   head_waddr,
   output logic [WORD_W-1:0] head_data,
   input  logic [WA_W-1:0]   srch_waddr,
   output logic              srch_hit,
   output logic [WORD_W-1:0] srch_data,
   output logic              srch_line_hit
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] wr_ptr;
   logic [CNT_W-1:0] cnt;
   logic [DEPTH-1:0][WA_W-1:0]   ent_a;
   logic [DEPTH-1:0][WORD_W-1:0] ent_d;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WA_W-1:0]   a_q;
      logic [WORD_W-1:0] d_q;
      always_ff @(posedge clk) begin
         if (push && (wr_ptr == PTR_W'(g))) begin
            a_q <= push_waddr;
            d_q <= push_data;
         end
      end
      assign ent_a[g] = a_q;
      assign ent_d[g] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign full       = (cnt == CNT_W'(DEPTH));
   assign head_valid = (cnt != '0);
   assign head_waddr = ent_a[rd_ptr];
   assign head_data  = ent_d[rd_ptr];

   // Walk from oldest to youngest so that the youngest match is the one kept.
   logic [PTR_W-1:0] slot;
   always_comb begin
      srch_hit      = 1'b0;
      srch_data     = '0;
      srch_line_hit = 1'b0;
      slot          = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = rd_ptr + PTR_W'(k);
         if (CNT_W'(k) < cnt) begin
            if (ent_a[slot] == srch_waddr) begin
               srch_hit  = 1'b1;
               srch_data = ent_d[slot];
            end
            if (ent_a[slot][WA_W-1:WSEL_W] == srch_waddr[WA_W-1:WSEL_W]) begin
               srch_line_hit = 1'b1;
            end
         end
      end
   end

   // R6: no store is taken while every entry is occupied
   a_r6_no_overflow : assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R9: the head write request holds until it is taken
   a_r9_wr_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && !pop) |=> (head_valid && $stable(head_waddr) && $stable(head_data)));

   // R11: removal only from a non-empty queue
   a_r11_pop_nonempty : assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_valid);

endmodule

// File: rtl/wtc_fill_ctrl.sv
module wtc_fill_ctrl
   import wtc_pkg::*;
#(
   parameter int LA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            miss_go,
   input  logic [LA_W-1:0] miss_line,
   input  logic            line_conflict,
   input  logic            rd_ready,
   input  logic            rd_data_valid,
   output logic            busy,
   output logic            rd_valid,
   output logic [LA_W-1:0] rd_line,
   output logic            fill_done
);

   fill_state_e     state_q;
   logic [LA_W-1:0] line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         line_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (miss_go) begin
                  line_q  <= miss_line;
                  state_q <= line_conflict ? FS_DRAIN_WAIT : FS_REQ;
               end
            end
            FS_DRAIN_WAIT: begin
               if (!line_conflict) state_q <= FS_REQ;
            end
            FS_REQ: begin
               if (rd_ready) state_q <= FS_WAIT;
            end
            FS_WAIT: begin
               if (rd_data_valid) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != FS_IDLE);
   assign rd_valid  = (state_q == FS_REQ);
   assign rd_line   = line_q;
   assign fill_done = (state_q == FS_WAIT) && rd_data_valid;

   // R8: no line read is offered while a queued store targets that line
   a_r8_fill_waits : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !line_conflict);

   // R9: the read request holds its address until accepted
   a_r9_rd_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_line)));

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
   import wtc_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int LINES      = 8,
   parameter int WB_DEPTH   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req_valid,
   output logic                    cpu_req_ready,
   input  logic                    cpu_req_we,
   input  logic [ADDR_W-1:0]       cpu_req_addr,
   input  logic [WORD_W-1:0]       cpu_req_wdata,
   output logic                    cpu_resp_valid,
   output logic [WORD_W-1:0]       cpu_resp_rdata,
   output logic                    mem_rd_valid,
   input  logic                    mem_rd_ready,
   output logic [ADDR_W-1:0]       mem_rd_addr,
   input  logic                    mem_rd_data_valid,
   input  logic [LINE_BYTES*8-1:0] mem_rd_data,
   output logic                    mem_wr_valid,
   input  logic                    mem_wr_ready,
   output logic [ADDR_W-1:0]       mem_wr_addr,
   output logic [WORD_W-1:0]       mem_wr_data
);

   localparam int WORD_BYTES = WORD_W / 8;
   localparam int BSEL_W     = $clog2(WORD_BYTES);
   localparam int OFF_W      = $clog2(LINE_BYTES);
   localparam int WSEL_W     = OFF_W - BSEL_W;
   localparam int IDX_W      = $clog2(LINES);
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
   localparam int WA_W       = ADDR_W - BSEL_W;
   localparam int LA_W       = ADDR_W - OFF_W;
   localparam int LINE_W     = LINE_BYTES * 8;

   if (!is_pow2(LINE_BYTES) || !is_pow2(LINES) || !is_pow2(WB_DEPTH) || (WB_DEPTH < 2)
       || (WORD_W % 8 != 0) || !is_pow2(WORD_BYTES) || (WORD_BYTES < 2)
       || (LINE_BYTES < 2 * WORD_BYTES) || (LINES < 2) || (TAG_W < 1)) begin : g_bad_cfg
      $error("wt_dcache: unsupported parameter set");
   end

   // request field split
   logic [WA_W-1:0]   req_wa;
   logic [IDX_W-1:0]  req_idx;
   logic [TAG_W-1:0]  req_tag;
   logic [WSEL_W-1:0] req_wsel;

   assign req_wa   = cpu_req_addr[ADDR_W-1:BSEL_W];
   assign req_idx  = cpu_req_addr[OFF_W +: IDX_W];
   assign req_tag  = cpu_req_addr[ADDR_W-1 -: TAG_W];
   assign req_wsel = cpu_req_addr[BSEL_W +: WSEL_W];

   // sub-block wiring
   logic              lk_valid;
   logic [TAG_W-1:0]  lk_tag;
   logic [LINE_W-1:0] lk_line;
   logic              wb_full;
   logic              wb_head_valid;
   logic [WA_W-1:0]   wb_head_waddr;
   logic [WORD_W-1:0] wb_head_data;
   logic [WA_W-1:0]   srch_waddr;
   logic              srch_hit;
   logic [WORD_W-1:0] srch_data;
   logic              srch_line_hit;
   logic              busy;
   logic              fill_done;
   logic [LA_W-1:0]   rd_line;
   logic [WA_W-1:0]   miss_wa_q;

   logic accept;
   logic ld_acc;
   logic st_acc;
   logic tag_hit;
   logic miss_go;
   logic wb_pop;

   assign cpu_req_ready = !busy && !(cpu_req_we && wb_full);
   assign accept        = cpu_req_valid && cpu_req_ready;
   assign ld_acc        = accept && !cpu_req_we;
   assign st_acc        = accept && cpu_req_we;
   assign tag_hit       = lk_valid && (lk_tag == req_tag);
   assign miss_go       = ld_acc && !tag_hit && !srch_hit;
   assign srch_waddr    = busy ? miss_wa_q : req_wa;
   assign wb_pop        = wb_head_valid && mem_wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_wa_q <= '0;
      end else if (miss_go) begin
         miss_wa_q <= req_wa;
      end
   end

   wtc_tag_store #(
      .LINES  (LINES),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .WORD_W (WORD_W),
      .WSEL_W (WSEL_W),
      .LINE_W (LINE_W)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_idx    (req_idx),
      .lk_valid  (lk_valid),
      .lk_tag    (lk_tag),
      .lk_line   (lk_line),
      .fill_en   (fill_done),
      .fill_idx  (miss_wa_q[WSEL_W +: IDX_W]),
      .fill_tag  (miss_wa_q[WA_W-1 -: TAG_W]),
      .fill_line (mem_rd_data),
      .wr_en     (st_acc && tag_hit),
      .wr_idx    (req_idx),
      .wr_wsel   (req_wsel),
      .wr_word   (cpu_req_wdata)
   );

   wtc_wbuf #(
      .DEPTH  (WB_DEPTH),
      .WA_W   (WA_W),
      .WORD_W (WORD_W),
      .WSEL_W (WSEL_W)
   ) u_wbuf (
      .clk           (clk),
      .rst_n         (rst_n),
      .push          (st_acc),
      .push_waddr    (req_wa),
      .push_data     (cpu_req_wdata),
      .full          (wb_full),
      .pop           (wb_pop),
      .head_valid    (wb_head_valid),
      .head_waddr    (wb_head_waddr),
      .head_data     (wb_head_data),
      .srch_waddr    (srch_waddr),
      .srch_hit      (srch_hit),
      .srch_data     (srch_data),
      .srch_line_hit (srch_line_hit)
   );

   wtc_fill_ctrl #(
      .LA_W (LA_W)
   ) u_fill (
      .clk           (clk),
      .rst_n         (rst_n),
      .miss_go       (miss_go),
      .miss_line     (req_wa[WA_W-1:WSEL_W]),
      .line_conflict (srch_line_hit),
      .rd_ready      (mem_rd_ready),
      .rd_data_valid (mem_rd_data_valid),
      .busy          (busy),
      .rd_valid      (mem_rd_valid),
      .rd_line       (rd_line),
      .fill_done     (fill_done)
   );

   assign mem_rd_addr  = {rd_line, {OFF_W{1'b0}}};
   assign mem_wr_valid = wb_head_valid;
   assign mem_wr_addr  = {wb_head_waddr, {BSEL_W{1'b0}}};
   assign mem_wr_data  = wb_head_data;

   // load response register
   logic [WORD_W-1:0] hit_word;
   logic [WORD_W-1:0] fill_word;

   assign hit_word  = lk_line[req_wsel*WORD_W +: WORD_W];
   assign fill_word = mem_rd_data[miss_wa_q[WSEL_W-1:0]*WORD_W +: WORD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_resp_valid <= 1'b0;
         cpu_resp_rdata <= '0;
      end else begin
         cpu_resp_valid <= fill_done || (ld_acc && (tag_hit || srch_hit));
         if (fill_done) begin
            cpu_resp_rdata <= fill_word;
         end else if (ld_acc) begin
            cpu_resp_rdata <= srch_hit ? srch_data : hit_word;
         end
      end
   end

   // R1: only word-aligned requests are issued
   a_r1_aligned : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req_valid |-> (cpu_req_addr[BSEL_W-1:0] == '0));

   // R2: a load that hits answers on the next cycle
   a_r2_hit_next : assert property (@(posedge clk) disable iff (!rst_n)
      (ld_acc && tag_hit) |=> cpu_resp_valid);

   // R4: an accepted store leaves a pending memory write behind it
   a_r4_store_queued : assert property (@(posedge clk) disable iff (!rst_n)
      st_acc |=> mem_wr_valid);

   // R3: no new request is taken while a line read is outstanding
   a_r3_block_in_fill : assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !cpu_req_ready);

endmodule

// File: tb/wt_dcache_tb.sv
module wt_dcache_tb;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req_valid = 1'b0;
   logic         cpu_req_ready;
   logic         cpu_req_we = 1'b0;
   logic [11:0]  cpu_req_addr = '0;
   logic [31:0]  cpu_req_wdata = '0;
   logic         cpu_resp_valid;
   logic [31:0]  cpu_resp_rdata;
   logic         mem_rd_valid;
   logic         mem_rd_ready;
   logic [11:0]  mem_rd_addr;
   logic         mem_rd_data_valid = 1'b0;
   logic [127:0] mem_rd_data = '0;
   logic         mem_wr_valid;
   logic         mem_wr_ready;
   logic [11:0]  mem_wr_addr;
   logic [31:0]  mem_wr_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   wt_dcache u_dut (
      .clk               (clk),
      .rst_n             (rst_n),
      .cpu_req_valid     (cpu_req_valid),
      .cpu_req_ready     (cpu_req_ready),
      .cpu_req_we        (cpu_req_we),
      .cpu_req_addr      (cpu_req_addr),
      .cpu_req_wdata     (cpu_req_wdata),
      .cpu_resp_valid    (cpu_resp_valid),
      .cpu_resp_rdata    (cpu_resp_rdata),
      .mem_rd_valid      (mem_rd_valid),
      .mem_rd_ready      (mem_rd_ready),
      .mem_rd_addr       (mem_rd_addr),
      .mem_rd_data_valid (mem_rd_data_valid),
      .mem_rd_data       (mem_rd_data),
      .mem_wr_valid      (mem_wr_valid),
      .mem_wr_ready      (mem_wr_ready),
      .mem_wr_addr       (mem_wr_addr),
      .mem_wr_data       (mem_wr_data)
   );

   // ---------------- memory model ----------------
   logic [31:0] mem   [1024];
   logic [31:0] ref_m [1024];
   logic        rd_gate = 1'b1;
   logic        wr_gate = 1'b1;
   logic        rd_busy = 1'b0;
   int          rd_cnt = 0;
   logic [11:0] rd_addr_q = '0;
   logic [11:0] rd_last = '0;
   int          rd_count = 0;
   logic [11:0] wl_a [64];
   logic [31:0] wl_d [64];
   int          wn = 0;

   assign mem_rd_ready = rd_gate;
   assign mem_wr_ready = wr_gate;

   function automatic logic [31:0] init_word(input int i);
      return 32'hC0DE0000 ^ (i * 32'h00010003);
   endfunction

   function automatic logic [127:0] line_of(input logic [11:0] a);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = mem[{a[11:4], 2'(k)}];
      return l;
   endfunction

   always @(posedge clk) begin
      mem_rd_data_valid <= 1'b0;
      if (rd_busy) begin
         if (rd_cnt == 1) begin
            mem_rd_data_valid <= 1'b1;
            mem_rd_data       <= line_of(rd_addr_q);
            rd_busy           <= 1'b0;
         end else begin
            rd_cnt <= rd_cnt - 1;
         end
      end
      if (mem_rd_valid && rd_gate) begin
         rd_busy   <= 1'b1;
         rd_cnt    <= 2;
         rd_addr_q <= mem_rd_addr;
         rd_last   <= mem_rd_addr;
         rd_count  <= rd_count + 1;
      end
      if (mem_wr_valid && wr_gate) begin
         mem[mem_wr_addr[11:2]] <= mem_wr_data;
         wl_a[wn[5:0]] <= mem_wr_addr;
         wl_d[wn[5:0]] <= mem_wr_data;
         wn <= wn + 1;
      end
   end

   // ---------------- bookkeeping ----------------
   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", r, act, exp);
      end
   endtask

   task automatic issue(input logic we, input logic [11:0] a, input logic [31:0] d);
      cpu_req_valid = 1'b1;
      cpu_req_we    = we;
      cpu_req_addr  = a;
      cpu_req_wdata = d;
      #1;
      while (!cpu_req_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      if (we) ref_m[a[11:2]] = d;
      @(negedge clk);
      cpu_req_valid = 1'b0;
   endtask

   task automatic wait_resp(output logic [31:0] d, output int n);
      n = 1;
      while (!cpu_resp_valid && n < 60) begin
         @(negedge clk);
         n++;
      end
      d = cpu_resp_rdata;
      if (!cpu_resp_valid) n = -1;
   endtask

   task automatic load_chk(input logic [11:0] a, input int exp_reads, input bit fast, input string r);
      logic [31:0] d;
      int n;
      int r0;
      r0 = rd_count;
      issue(1'b0, a, '0);
      wait_resp(d, n);
      chk(d == ref_m[a[11:2]], r, d, ref_m[a[11:2]]);
      chk(rd_count - r0 == exp_reads, {r, " reads"}, rd_count - r0, exp_reads);
      if (fast) chk(n == 1, {r, " latency"}, n, 1);
   endtask

   task automatic drain();
      int i;
      i = 0;
      while (mem_wr_valid && i < 200) begin
         @(negedge clk);
         i++;
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(!mem_rd_valid && !mem_wr_valid, "R10 no pending request", {mem_rd_valid, mem_wr_valid}, 0);
      chk(cpu_req_ready && !cpu_resp_valid, "R10 idle after reset", {cpu_req_ready, cpu_resp_valid}, 2);
      load_chk(12'h000, 1, 0, "R10 first load misses");
   endtask

   task automatic t_miss_hit();
      load_chk(12'h044, 1, 0, "R3 miss fill");
      chk(rd_last == 12'h040, "R3 line aligned read", rd_last, 12'h040);
      load_chk(12'h048, 0, 1, "R2 hit same line");
   endtask

   task automatic t_alias();
      load_chk(12'h0C4, 1, 0, "R1 alias tag fill");
      load_chk(12'h048, 1, 0, "R1 evicted by alias");
   endtask

   task automatic t_store_hit();
      issue(1'b1, 12'h04C, 32'h11112222);
      drain();
      chk(wl_a[(wn-1) & 63] == 12'h04C && wl_d[(wn-1) & 63] == 32'h11112222,
          "R4 write reaches memory", wl_d[(wn-1) & 63], 32'h11112222);
      load_chk(12'h04C, 0, 1, "R4 store hit updates line");
   endtask

   task automatic t_store_miss();
      issue(1'b1, 12'h208, 32'h33334444);
      drain();
      chk(mem[12'h208 >> 2] == 32'h33334444, "R4 miss store in memory", mem[12'h208 >> 2], 32'h33334444);
      load_chk(12'h208, 1, 0, "R5 no allocate on store miss");
   endtask

   task automatic t_full_fwd();
      int ws;
      logic [31:0] exp_d [5];
      exp_d[0] = 32'hA1A1A1A1; exp_d[1] = 32'hB2B2B2B2; exp_d[2] = 32'hC3C3C3C3;
      exp_d[3] = 32'hD4D4D4D4; exp_d[4] = 32'hE5E5E5E5;
      wr_gate = 1'b0;
      ws = wn;
      issue(1'b1, 12'h300, exp_d[0]);
      issue(1'b1, 12'h304, exp_d[1]);
      issue(1'b1, 12'h300, exp_d[2]);
      issue(1'b1, 12'h380, exp_d[3]);
      load_chk(12'h300, 0, 1, "R7 youngest match forwarded");
      load_chk(12'h304, 0, 1, "R7 older single match forwarded");
      cpu_req_valid = 1'b1; cpu_req_we = 1'b1; cpu_req_addr = 12'h308; cpu_req_wdata = exp_d[4];
      #1;
      chk(!cpu_req_ready, "R6 stall when full", cpu_req_ready, 0);
      repeat (2) @(negedge clk);
      #1;
      chk(!cpu_req_ready, "R6 stall persists", cpu_req_ready, 0);
      wr_gate = 1'b1;
      issue(1'b1, 12'h308, exp_d[4]);
      drain();
      chk(wn - ws == 5, "R11 write count", wn - ws, 5);
      for (int i = 0; i < 5; i++) begin
         chk(wl_d[(ws + i) & 63] == exp_d[i], "R11 drain order", wl_d[(ws + i) & 63], exp_d[i]);
      end
      load_chk(12'h300, 1, 0, "R5 forwarded line not allocated");
   endtask

   task automatic t_same_line();
      logic [31:0] d;
      int n;
      wr_gate = 1'b0;
      issue(1'b1, 12'h3C0, 32'hF6F6F6F6);
      issue(1'b0, 12'h3C4, '0);
      for (int i = 0; i < 6; i++) begin
         chk(!mem_rd_valid, "R8 fill held behind same-line store", mem_rd_valid, 0);
         @(negedge clk);
      end
      wr_gate = 1'b1;
      wait_resp(d, n);
      chk(n > 0 && d == ref_m[12'h3C4 >> 2], "R8 fill after drain", d, ref_m[12'h3C4 >> 2]);
      load_chk(12'h3C0, 0, 1, "R8 filled line holds drained store");
   endtask

   task automatic t_other_line();
      wr_gate = 1'b0;
      issue(1'b1, 12'h500, 32'h77777777);
      load_chk(12'h514, 1, 0, "R8 fill overtakes other-line store");
      chk(mem_wr_valid, "R8 store still queued", mem_wr_valid, 1);
      wr_gate = 1'b1;
      drain();
      chk(mem[12'h500 >> 2] == 32'h77777777, "R4 late store lands", mem[12'h500 >> 2], 32'h77777777);
   endtask

   task automatic t_rd_hold();
      logic [31:0] d;
      int n;
      rd_gate = 1'b0;
      issue(1'b0, 12'h600, '0);
      for (int i = 0; i < 4; i++) begin
         chk(mem_rd_valid && mem_rd_addr == 12'h600, "R9 read request held", {19'd0, mem_rd_valid, mem_rd_addr}, 32'h1600);
         @(negedge clk);
      end
      rd_gate = 1'b1;
      wait_resp(d, n);
      chk(n > 0 && d == ref_m[12'h600 >> 2], "R9 data after stall", d, ref_m[12'h600 >> 2]);
   endtask

   // ---------------- sequencing ----------------
   initial begin
      for (int i = 0; i < 1024; i++) begin
         mem[i]   = init_word(i);
         ref_m[i] = init_word(i);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_miss_hit();
      t_alias();
      t_store_hit();
      t_store_miss();
      t_full_fwd();
      t_same_line();
      t_other_line();
      t_rd_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule